// File: doc/BRIEF.md
# Compliance-Mode Mailbox Responder

This block answers compliance-mode requests that a host delivers as mailbox data objects. A request arrives one dword at a time on a valid/ready stream. The first dword is the object header, carrying a 16-bit vendor ID and an 8-bit object type. The second dword is the object length. The payload starts in the third dword, and byte 0 of that dword holds the request code. The block reads that code, selects a response format, builds the response image, and sends it back as a dword stream on a second valid/ready interface. The final dword is flagged with a last marker.

The two query codes return structures whose sizes are not whole dwords. The block packs their bytes little-endian into dwords and fills the unused tail bytes with zero. It reports the object length as the byte size rounded up to whole dwords. The test-action codes only receive an acknowledgement, because carrying out the test actions is the job of other logic. Unknown codes, headers that do not match, and objects too short to hold a code are answered with a nonzero status.

Top module: `cmpl_mbox_responder`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Every response starts with header dword 0x00001E98 (vendor ID in bits 15:0, object type 0 in bits 23:16). Its second dword is the object length in dwords, which is the structure byte size divided by 4 and rounded up. That length matches the number of dwords actually sent.
- R3: Request code 0x00 returns 7 dwords. Dword 2 is 0x001C0100 (response code 0, version 1, internal length 0x1C, status 0). Dwords 3/4 hold the 64-bit available mask and dwords 5/6 hold the 64-bit enabled mask, each equal to 0x3.
- R4: Request code 0x01 returns an 18-byte structure sent in 5 dwords. Byte 8 is response code 1, byte 9 is version 1, byte 10 is internal length 0x14, bytes 11–14 hold a 32-bit capability field of 0x3, bytes 15–16 hold cache size 0, and byte 17 holds cache units 0.
- R5: Request codes 0x02 to 0x0E return 3 dwords. Dword 2 is {status 0x00, length 0x0C, version 0x01, request code}, from the most significant byte down.
- R6: Request codes 0x0F to 0xFF return 3 dwords with dword 2 = {0x01, 0x0C, 0x01, request code}.
- R7: A request whose header has the wrong vendor ID or a nonzero type returns 3 dwords with status 0x02 and the request code echoed. A request of fewer than 3 dwords returns status 0x02 with response code 0xFF.
- R8: Response bytes are packed little-endian, so byte 4k+j lands in bits 8j+7:8j of dword k. Pad bytes beyond the structure size read as zero.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_last` hold steady. `rsp_last` is high only on the final dword.
- R10: The response begins in the cycle after the last request dword is accepted. `req_ready` stays low from then until the final response dword is accepted.
- R11: Only byte 0 of the third request dword selects the response. Its upper bytes and any further payload dwords have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request dword valid |
| req_ready | output | 1 | Request dword accepted when high with valid |
| req_data | input | 32 | Request dword |
| req_last | input | 1 | Marks the final request dword |
| rsp_valid | output | 1 | Response dword valid |
| rsp_ready | input | 1 | Downstream accepts response dword |
| rsp_data | output | 32 | Response dword |
| rsp_last | output | 1 | Marks the final response dword |

## Verification
All 256 request codes are swept with a free-running consumer. This separates the two query layouts, the acknowledged action range, and the unsupported range, and it pins down both edges at 0x0E/0x0F. A second pass uses a stalling consumer and longer request objects with junk in the upper bytes of the payload. This shows that stalls hold the output steady and that only the code byte steers the reply. Headers with a wrong vendor, headers with a wrong type, and objects of one or two dwords exercise the error status path and the missing-code value.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

    localparam int RSP_MAX_BYTES = 28;
    localparam int RSP_MAX_DW    = RSP_MAX_BYTES / 4;
    localparam int NDW_W         = $clog2(RSP_MAX_DW + 1);
    localparam int CAP_BYTES     = 28;
    localparam int STAT_BYTES    = 18;
    localparam int ACK_BYTES     = 12;

    typedef struct packed {
        logic [15:0] vendor;
        logic [7:0]  obj_type;
        logic [7:0]  version;
        logic [63:0] avail_caps;
        logic [63:0] enabled_caps;
        logic [31:0] status_caps;
        logic [15:0] cache_size;
        logic [7:0]  cache_units;
        logic [7:0]  last_action;
    } cfg_t;

    typedef struct packed {
        logic [7:0] code;
        logic       hdr_ok;
        logic       has_code;
    } req_info_t;

    typedef struct packed {
        logic [RSP_MAX_BYTES-1:0][7:0] bytes;
        logic [NDW_W-1:0]              ndw;
    } rsp_img_t;

    function automatic logic [NDW_W-1:0] dw_round(int nbytes);
        return NDW_W'((nbytes + 3) / 4);
    endfunction

    function automatic rsp_img_t build_rsp(req_info_t r, cfg_t c);
        rsp_img_t   img;
        int         sz;
        logic [7:0] code;
        logic [7:0] status;
        img    = '0;
        code   = r.has_code ? r.code : 8'hFF;
        status = 8'h00;
        if (!r.has_code || !r.hdr_ok) begin
            sz     = ACK_BYTES;
            status = 8'h02;
        end else if (code == 8'h00) begin
            sz = CAP_BYTES;
        end else if (code == 8'h01) begin
            sz = STAT_BYTES;
        end else begin
            sz     = ACK_BYTES;
            status = (code <= c.last_action) ? 8'h00 : 8'h01;
        end
        img.ndw      = dw_round(sz);
        img.bytes[0] = c.vendor[7:0];
        img.bytes[1] = c.vendor[15:8];
        img.bytes[2] = c.obj_type;
        img.bytes[4] = 8'(img.ndw);
        img.bytes[8] = code;
        img.bytes[9] = c.version;
        if (sz == CAP_BYTES) begin
            img.bytes[10] = 8'h1C;
            img.bytes[11] = 8'h00;
            for (int i = 0; i < 8; i++) begin
                img.bytes[12 + i] = c.avail_caps[8*i +: 8];
                img.bytes[20 + i] = c.enabled_caps[8*i +: 8];
            end
        end else if (sz == STAT_BYTES) begin
            img.bytes[10] = 8'h14;
            for (int i = 0; i < 4; i++)
                img.bytes[11 + i] = c.status_caps[8*i +: 8];
            img.bytes[15] = c.cache_size[7:0];
            img.bytes[16] = c.cache_size[15:8];
            img.bytes[17] = c.cache_units;
        end else begin
            img.bytes[10] = 8'(ACK_BYTES);
            img.bytes[11] = status;
        end
        return img;
    endfunction

endpackage

// File: rtl/cmr_req_parse.sv
module cmr_req_parse
    import cmr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1E98,
    parameter logic [7:0]  OBJ_TYPE  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        accept_en,
    input  logic        req_valid,
    input  logic [31:0] req_data,
    input  logic        req_last,
    output logic        req_ready,
    output logic        obj_done,
    output req_info_t   info
);
    logic [1:0] beat_q;
    logic       hdr_ok_q;
    logic       has_code_q;
    logic [7:0] code_q;
    logic       fire;
    logic       cur_match;

    assign req_ready = accept_en;
    assign fire      = req_valid && req_ready;
    assign obj_done  = fire && req_last;
    assign cur_match = (req_data[15:0] == VENDOR_ID) && (req_data[23:16] == OBJ_TYPE);

    always_comb begin
        info.hdr_ok   = (beat_q == 2'd0) ? cur_match : hdr_ok_q;
        info.has_code = (beat_q == 2'd2) ? 1'b1 : has_code_q;
        info.code     = (beat_q == 2'd2) ? req_data[7:0] : code_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q     <= 2'd0;
            hdr_ok_q   <= 1'b0;
            has_code_q <= 1'b0;
            code_q     <= 8'h00;
        end else if (fire) begin
            if (req_last) begin
                beat_q     <= 2'd0;
                has_code_q <= 1'b0;
            end else begin
                if (beat_q != 2'd3) beat_q <= beat_q + 2'd1;
                if (beat_q == 2'd0) begin
                    hdr_ok_q   <= cur_match;
                    has_code_q <= 1'b0;
                end
                if (beat_q == 2'd2) begin
                    code_q     <= req_data[7:0];
                    has_code_q <= 1'b1;
                end
            end
        end
    end

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        obj_done |=> !req_ready) else $error("ready after last");  // R10

endmodule

// File: rtl/cmr_rsp_stream.sv
module cmr_rsp_stream
    import cmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  rsp_img_t    img_in,
    input  logic        rsp_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        rsp_last,
    output logic        busy
);
    rsp_img_t         img_q;
    logic [NDW_W-1:0] idx_q;
    logic             busy_q;

    assign busy      = busy_q;
    assign rsp_valid = busy_q;
    assign rsp_data  = img_q.bytes[{idx_q, 2'b00} +: 4];
    assign rsp_last  = busy_q && (idx_q == img_q.ndw - NDW_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            img_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (load && !busy_q) begin
            img_q  <= img_in;
            idx_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && rsp_ready) begin
            if (rsp_last) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + NDW_W'(1);
            end
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (idx_q < img_q.ndw)) else $error("index past end");  // R9

endmodule

// File: rtl/cmpl_mbox_responder.sv
module cmpl_mbox_responder
    import cmr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'h1E98,
    parameter logic [7:0]  OBJ_TYPE     = 8'h00,
    parameter logic [7:0]  RSP_VERSION  = 8'h01,
    parameter logic [63:0] AVAIL_CAPS   = 64'h3,
    parameter logic [63:0] ENABLED_CAPS = 64'h3,
    parameter logic [31:0] STATUS_CAPS  = 32'h3,
    parameter logic [15:0] CACHE_SIZE   = 16'h0,
    parameter logic [7:0]  CACHE_UNITS  = 8'h0,
    parameter logic [7:0]  LAST_ACTION  = 8'h0E
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_data,
    input  logic        req_last,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_data,
    output logic        rsp_last
);
    localparam cfg_t CFG = '{
        vendor:       VENDOR_ID,
        obj_type:     OBJ_TYPE,
        version:      RSP_VERSION,
        avail_caps:   AVAIL_CAPS,
        enabled_caps: ENABLED_CAPS,
        status_caps:  STATUS_CAPS,
        cache_size:   CACHE_SIZE,
        cache_units:  CACHE_UNITS,
        last_action:  LAST_ACTION
    };

    logic      busy;
    logic      obj_done;
    req_info_t info;
    rsp_img_t  img;

    cmr_req_parse #(
        .VENDOR_ID (VENDOR_ID),
        .OBJ_TYPE  (OBJ_TYPE)
    ) u_parse (
        .clk       (clk),
        .rst       (rst),
        .accept_en (!busy),
        .req_valid (req_valid),
        .req_data  (req_data),
        .req_last  (req_last),
        .req_ready (req_ready),
        .obj_done  (obj_done),
        .info      (info)
    );

    assign img = build_rsp(info, CFG);

    cmr_rsp_stream u_stream (
        .clk       (clk),
        .rst       (rst),
        .load      (obj_done),
        .img_in    (img),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last),
        .busy      (busy)
    );

    // Port-side monitor state for the checks below.
    logic                 mon_first;
    logic [NDW_W-1:0]     mon_cnt;
    logic [31:0]          mon_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_first <= 1'b1;
            mon_cnt   <= '0;
            mon_len   <= '0;
        end else if (rsp_valid && rsp_ready) begin
            mon_first <= rsp_last;
            mon_cnt   <= rsp_last ? '0 : mon_cnt + NDW_W'(1);
            if (mon_cnt == NDW_W'(1)) mon_len <= rsp_data;
        end
    end

    AST_HDR_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && mon_first) |-> (rsp_data == {8'h00, OBJ_TYPE, VENDOR_ID}))
        else $error("bad header dword");  // R2

    AST_LEN_MATCH: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready && rsp_last) |-> ((32'(mon_cnt) + 32'd1) == mon_len))
        else $error("length mismatch");  // R2

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)))
        else $error("output moved under stall");  // R9

    AST_START_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> $past(req_valid && req_ready && req_last))
        else $error("response without request");  // R10

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready) else $error("accepting while responding");  // R10

endmodule

// File: tb/cmpl_mbox_responder_tb.sv
module cmpl_mbox_responder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_data = '0;
    logic        req_last = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;
    logic        rsp_last;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmpl_mbox_responder u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data), .req_last(req_last),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_last(rsp_last)
    );

    task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h (t=%0t)", req, got, exp, $time);
        end
    endtask

    // kind: 0 well-formed, 1 bad header, 2 too short
    function automatic int exp_ndw(int kind, int code);
        if (kind != 0) return 3;
        if (code == 0) return 7;
        if (code == 1) return 5;
        return 3;
    endfunction

    function automatic logic [31:0] exp_dw(int kind, int code, int i);
        logic [7:0] st;
        logic [7:0] cd;
        if (i == 0) return 32'h0000_1E98;
        if (i == 1) return 32'(exp_ndw(kind, code));
        if (kind == 0 && code == 0) begin
            case (i)
                2: return 32'h001C_0100;
                3: return 32'h3;
                5: return 32'h3;
                default: return 32'h0;
            endcase
        end
        if (kind == 0 && code == 1) begin
            // byte 11 holds low byte of capability field (3)
            if (i == 2) return 32'h0314_0101;
            return 32'h0;
        end
        cd = (kind == 2) ? 8'hFF : 8'(code);
        if (kind != 0)       st = 8'h02;
        else if (code <= 14) st = 8'h00;
        else                 st = 8'h01;
        return {st, 8'h0C, 8'h01, cd};
    endfunction

    function automatic string tag_of(int kind, int code, int i);
        if (i < 2) return "R2";
        if (kind != 0) return "R7";
        if (code == 0) return "R3";
        if (code == 1) return (i == 4) ? "R8" : "R4";
        if (code <= 14) return "R5";
        return "R6";
    endfunction

    // nwords: request object size; hdr: first dword
    task automatic send(logic [31:0] hdr, int nwords, int code);
        for (int i = 0; i < nwords; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_last  = (i == nwords - 1);
            case (i)
                0: req_data = hdr;
                1: req_data = 32'(nwords);
                2: req_data = {8'hA5, 8'h5A, 8'h01, 8'(code)};
                default: req_data = 32'hDEAD_0000 | 32'(i);
            endcase
            while (!req_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_last  = 1'b0;
        chk(rsp_valid === 1'b1, "R10", {31'd0, rsp_valid}, 32'd1);
        chk(req_ready === 1'b0, "R10", {31'd0, req_ready}, 32'd0);
    endtask

    task automatic collect(int kind, int code, bit stall, string xtag);
        int n;
        int beat;
        logic [31:0] held;
        logic        was_stalled;
        n = exp_ndw(kind, code);
        beat = 0;
        was_stalled = 1'b0;
        held = '0;
        while (beat < n) begin
            rsp_ready = stall ? ((cyc % 3) != 0) : 1'b1;
            if (was_stalled)
                chk(rsp_valid && rsp_data === held, "R9", rsp_data, held);
            was_stalled = 1'b0;
            if (rsp_valid && rsp_ready) begin
                chk(rsp_data === exp_dw(kind, code, beat),
                    (xtag != "") ? xtag : tag_of(kind, code, beat),
                    rsp_data, exp_dw(kind, code, beat));
                chk(rsp_last === (beat == n - 1), "R9", {31'd0, rsp_last},
                    {31'd0, (beat == n - 1)});
                beat++;
            end else if (rsp_valid) begin
                held = rsp_data;
                was_stalled = 1'b1;
            end
            @(negedge clk);
        end
        rsp_ready = 1'b0;
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R10",
            {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R1", {31'd0, rsp_valid}, 32'd0);
        chk(req_ready === 1'b1, "R1", {31'd0, req_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R1",
            {30'd0, rsp_valid, req_ready}, 32'd1);

        // full code sweep, free-running consumer
        for (int c = 0; c < 256; c++) begin
            send(32'h0000_1E98, 3, c);
            collect(0, c, 1'b0, "");
        end

        // stalling consumer, longer payloads with junk (R11)
        for (int c = 0; c < 20; c++) begin
            send(32'h0000_1E98, 3 + (c % 4), c);
            collect(0, c, 1'b1, (c % 4 != 0) ? "R11" : "");
        end

        // malformed headers (R7)
        for (int c = 0; c < 4; c++) begin
            send(32'h0000_1E99, 3, c);
            collect(1, c, 1'b0, "R7");
            send(32'h0001_1E98, 4, c);
            collect(1, c, 1'b1, "R7");
        end

        // too short to carry a code (R7)
        send(32'h0000_1E98, 2, 0);
        collect(2, 0, 1'b0, "R7");
        send(32'h0000_1E98, 1, 0);
        collect(2, 0, 1'b1, "R7");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule